// File: doc/BRIEF.md
# Privilege Status Register Controller

This block keeps the processor's status control word and turns it into the signals the rest of the core needs each cycle. From the stored word it derives the current privilege level, a gated interrupt request, and a permission check for a memory access aimed at one of three address segments. It also reports whether wide (64-bit) operations are legal in the current level, and which of two refill exceptions a translation miss should raise.

Software reads and writes the word through a simple port. Three inputs force reset values into the word: a cold reset, a soft reset and a non-maskable interrupt. An exception-entry strobe and an exception-return strobe move the two exception-level flags. Every decoded output is combinational from the stored word and the request inputs. A change to the word is therefore visible on the outputs in the cycle after the clock edge that stores it.

Top module: `priv_status_ctl`

## Requirements
- R1: The status word has these fields: bit 0 global interrupt enable, bit 1 exception level, bit 2 error level, bits 4:3 privilege field, bit 5 user wide enable, bit 6 supervisor wide enable, bit 7 kernel wide enable, bits 15:8 interrupt mask, bit 20 soft-reset flag, bit 21 shutdown flag, bit 22 boot-vector flag. A write stores these fields at the next clock edge. `rd_data` returns the stored word, and every other bit reads 0.
- R2: `cur_mode` is 2'b00 (kernel) when the exception level is 1, or the error level is 1, or the privilege field is 00. Otherwise it is 2'b01 (supervisor) when the field is 01, and 2'b10 (user) when the field is 10 or 11.
- R3: `irq_req` is 1 only when the enable bit is 1, both level bits are 0, and at least one line has both its `irq_pend` bit and its mask bit at 1.
- R4: With `acc_req` at 1, `acc_fault` is 1 in these cases: a kernel-segment access (`acc_seg` 00) in any level other than kernel; a supervisor-segment access (01) in user level; any access with segment code 11. A user-segment access (10) never faults. With `acc_req` at 0, `acc_fault` is 0.
- R5: `op64_ok` is 1 in kernel level whatever the kernel wide bit holds. In supervisor level it equals the supervisor wide bit, and in user level it equals the user wide bit.
- R6: `xrefill_sel` equals the wide bit of the level that owns `miss_seg`: 00 selects the kernel bit, 01 the supervisor bit, 10 the user bit. Code 11 gives 0.
- R7: A cold reset sets the error level and boot-vector flag to 1, and clears the soft-reset flag and the shutdown flag.
- R8: A soft reset or NMI sets the soft-reset flag, the error level and the boot-vector flag to 1, and leaves every other field unchanged.
- R9: An exception-entry strobe sets the exception level to 1.
- R10: An exception-return strobe clears the error level if it is 1. Otherwise it clears the exception level.
- R11: The update priority is cold reset, then soft reset or NMI, then exception entry, then exception return, then software write. A write in the same cycle as a strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, active high |
| soft_rst | input | 1 | Soft reset request |
| nmi | input | 1 | Non-maskable interrupt request |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Stored status word |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_return | input | 1 | Exception-return strobe |
| irq_pend | input | 8 | Pending interrupt lines |
| acc_req | input | 1 | Access check request |
| acc_seg | input | 2 | Target segment of the access |
| miss_seg | input | 2 | Segment of a translation miss |
| cur_mode | output | 2 | Current privilege level |
| irq_req | output | 1 | Interrupt request to the pipeline |
| acc_fault | output | 1 | Access not permitted |
| xrefill_sel | output | 1 | Selects the extended refill exception |
| op64_ok | output | 1 | Wide operations legal in current level |

## Verification
The bench writes every combination of the low byte: the enable, both level bits, the privilege field and all three wide bits. For each one it checks the level, every access segment and every miss segment. A design that let the privilege field win over a raised level bit would report supervisor or user level during an exception. A design that gated kernel wide operations with the kernel wide bit would drop `op64_ok` in kernel level. The interrupt sweep crosses the enable and level bits with several mask and pending patterns, so a gate that ignored either level bit, or ORed pending lines without their mask, would raise a stray request. Directed sequences cover the return strobe clearing the error level before the exception level, a write dropped under a strobe, and a soft reset that must keep the other fields. A design that cleared the word on soft reset, or let the write win, would show a wrong readback.

// File: rtl/psr_pkg.sv
package psr_pkg;

   // field positions of the status word
   localparam int B_IEN = 0;
   localparam int B_EXC = 1;
   localparam int B_ERR = 2;
   localparam int B_PM  = 3;   // two bits: B_PM+1 : B_PM
   localparam int B_WU  = 5;
   localparam int B_WS  = 6;
   localparam int B_WK  = 7;
   localparam int B_IM  = 8;   // mask field starts here
   localparam int B_SR  = 20;
   localparam int B_TS  = 21;
   localparam int B_BEV = 22;
   localparam int STAT_MIN_W = B_BEV + 1;
   localparam int IM_MAX_W   = B_SR - B_IM;

   typedef enum logic [1:0] {
      PRIV_KERN = 2'b00,
      PRIV_SUPV = 2'b01,
      PRIV_USER = 2'b10
   } priv_e;

   localparam logic [1:0] SEG_KERN = 2'b00;
   localparam logic [1:0] SEG_SUPV = 2'b01;
   localparam logic [1:0] SEG_USER = 2'b10;

endpackage

// File: rtl/psr_state.sv
module psr_state
   import psr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IRQ_N  = 8
) (
   input  logic              clk,
   input  logic              cold_rst,
   input  logic              soft_rst,
   input  logic              nmi,
   input  logic              exc_enter,
   input  logic              exc_return,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] stat_q
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
   localparam logic [DATA_W-1:0] IM_MASK = ((ONE << IRQ_N) - ONE) << B_IM;
   localparam logic [DATA_W-1:0] WR_MASK =
      (ONE << B_IEN) | (ONE << B_EXC) | (ONE << B_ERR) |
      (ONE << B_PM)  | (ONE << (B_PM + 1)) |
      (ONE << B_WU)  | (ONE << B_WS)  | (ONE << B_WK) |
      IM_MASK |
      (ONE << B_SR)  | (ONE << B_TS)  | (ONE << B_BEV);
   // undefined bits are forced to zero so that simulation stays deterministic
   localparam logic [DATA_W-1:0] COLD_VAL = (ONE << B_ERR) | (ONE << B_BEV);

   logic [DATA_W-1:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (soft_rst || nmi) begin
         stat_d[B_SR]  = 1'b1;
         stat_d[B_ERR] = 1'b1;
         stat_d[B_BEV] = 1'b1;
      end else if (exc_enter) begin
         stat_d[B_EXC] = 1'b1;
      end else if (exc_return) begin
         if (stat_q[B_ERR]) begin
            stat_d[B_ERR] = 1'b0;
         end else begin
            stat_d[B_EXC] = 1'b0;
         end
      end else if (wr_en) begin
         stat_d = wr_data & WR_MASK;
      end
   end

   always_ff @(posedge clk) begin
      if (cold_rst) begin
         stat_q <= COLD_VAL;
      end else begin
         stat_q <= stat_d;
      end
   end

endmodule

// File: rtl/psr_mode_dec.sv
module psr_mode_dec
   import psr_pkg::*;
#(
   parameter bit RSVD_AS_USER = 1'b1   // privilege field 11: user (1) or kernel (0)
) (
   input  logic       exc_lvl,
   input  logic       err_lvl,
   input  logic [1:0] pm_fld,
   input  logic       wide_k,
   input  logic       wide_s,
   input  logic       wide_u,
   output priv_e      mode,
   output logic       op64_ok
);

   always_comb begin
      if (exc_lvl || err_lvl) begin
         mode = PRIV_KERN;
      end else begin
         unique case (pm_fld)
            2'b00:   mode = PRIV_KERN;
            2'b01:   mode = PRIV_SUPV;
            2'b10:   mode = PRIV_USER;
            default: mode = RSVD_AS_USER ? PRIV_USER : PRIV_KERN;
         endcase
      end
   end

   logic unused_wide_k;
   assign unused_wide_k = wide_k;   // kernel level always allows wide operations

   always_comb begin
      unique case (mode)
         PRIV_SUPV: op64_ok = wide_s;
         PRIV_USER: op64_ok = wide_u;
         default:   op64_ok = 1'b1;
      endcase
   end

endmodule

// File: rtl/psr_access.sv
module psr_access
   import psr_pkg::*;
(
   input  priv_e      mode,
   input  logic       acc_req,
   input  logic [1:0] acc_seg,
   input  logic [1:0] miss_seg,
   input  logic       wide_k,
   input  logic       wide_s,
   input  logic       wide_u,
   output logic       acc_fault,
   output logic       xrefill_sel
);

   logic allowed;

   always_comb begin
      unique case (acc_seg)
         SEG_KERN: allowed = (mode == PRIV_KERN);
         SEG_SUPV: allowed = (mode != PRIV_USER);
         SEG_USER: allowed = 1'b1;
         default:  allowed = 1'b0;
      endcase
      acc_fault = acc_req && !allowed;
   end

   always_comb begin
      unique case (miss_seg)
         SEG_KERN: xrefill_sel = wide_k;
         SEG_SUPV: xrefill_sel = wide_s;
         SEG_USER: xrefill_sel = wide_u;
         default:  xrefill_sel = 1'b0;
      endcase
   end

endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
   parameter int IRQ_N = 8
) (
   input  logic             ien,
   input  logic             exc_lvl,
   input  logic             err_lvl,
   input  logic [IRQ_N-1:0] mask,
   input  logic [IRQ_N-1:0] pend,
   output logic             irq
);

   logic [IRQ_N-1:0] hit;

   for (genvar i = 0; i < IRQ_N; i++) begin : g_line
      assign hit[i] = pend[i] & mask[i];
   end

   assign irq = ien && !exc_lvl && !err_lvl && (|hit);

endmodule

// File: rtl/priv_status_ctl.sv
module priv_status_ctl
   import psr_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IRQ_N        = 8,
   parameter bit RSVD_AS_USER = 1'b1
) (
   input  logic              clk,
   input  logic              cold_rst,
   input  logic              soft_rst,
   input  logic              nmi,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              exc_enter,
   input  logic              exc_return,
   input  logic [IRQ_N-1:0]  irq_pend,
   input  logic              acc_req,
   input  logic [1:0]        acc_seg,
   input  logic [1:0]        miss_seg,
   output logic [1:0]        cur_mode,
   output logic              irq_req,
   output logic              acc_fault,
   output logic              xrefill_sel,
   output logic              op64_ok
);

   if (DATA_W < STAT_MIN_W) begin : g_bad_width
      $error("priv_status_ctl: DATA_W too small for the status layout");
   end
   if (IRQ_N < 1 || IRQ_N > IM_MAX_W) begin : g_bad_irq
      $error("priv_status_ctl: IRQ_N out of range");
   end

   logic [DATA_W-1:0] stat;
   priv_e             mode;

   psr_state #(
      .DATA_W (DATA_W),
      .IRQ_N  (IRQ_N)
   ) u_state (
      .clk        (clk),
      .cold_rst   (cold_rst),
      .soft_rst   (soft_rst),
      .nmi        (nmi),
      .exc_enter  (exc_enter),
      .exc_return (exc_return),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .stat_q     (stat)
   );

   psr_mode_dec #(
      .RSVD_AS_USER (RSVD_AS_USER)
   ) u_mode (
      .exc_lvl (stat[B_EXC]),
      .err_lvl (stat[B_ERR]),
      .pm_fld  (stat[B_PM +: 2]),
      .wide_k  (stat[B_WK]),
      .wide_s  (stat[B_WS]),
      .wide_u  (stat[B_WU]),
      .mode    (mode),
      .op64_ok (op64_ok)
   );

   psr_access u_access (
      .mode        (mode),
      .acc_req     (acc_req),
      .acc_seg     (acc_seg),
      .miss_seg    (miss_seg),
      .wide_k      (stat[B_WK]),
      .wide_s      (stat[B_WS]),
      .wide_u      (stat[B_WU]),
      .acc_fault   (acc_fault),
      .xrefill_sel (xrefill_sel)
   );

   psr_irq_gate #(
      .IRQ_N (IRQ_N)
   ) u_irq (
      .ien     (stat[B_IEN]),
      .exc_lvl (stat[B_EXC]),
      .err_lvl (stat[B_ERR]),
      .mask    (stat[B_IM +: IRQ_N]),
      .pend    (irq_pend),
      .irq     (irq_req)
   );

   assign rd_data  = stat;
   assign cur_mode = mode;

endmodule

// File: rtl/psr_status_chk.sv
module psr_status_chk (
   input logic       clk,
   input logic       cold_rst,
   input logic       soft_rst,
   input logic       nmi,
   input logic       exc_enter,
   input logic       st_ien,
   input logic       st_exc,
   input logic       st_err,
   input logic       st_sr,
   input logic       st_bev,
   input logic [1:0] cur_mode,
   input logic       irq_req,
   input logic       acc_req,
   input logic [1:0] acc_seg,
   input logic       acc_fault,
   input logic       op64_ok
);

   AST_LEVEL_KERNEL: assert property (@(posedge clk) disable iff (cold_rst)
      (st_exc || st_err) |-> (cur_mode == 2'b00)); // R2

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (cold_rst)
      irq_req |-> (st_ien && !st_exc && !st_err)); // R3

   AST_KSEG_FAULT: assert property (@(posedge clk) disable iff (cold_rst)
      (acc_req && acc_seg == 2'b00 && cur_mode != 2'b00) |-> acc_fault); // R4

   AST_USEG_OK: assert property (@(posedge clk) disable iff (cold_rst)
      (acc_req && acc_seg == 2'b10) |-> !acc_fault); // R4

   AST_KERNEL_WIDE: assert property (@(posedge clk) disable iff (cold_rst)
      (cur_mode == 2'b00) |-> op64_ok); // R5

   AST_SOFT_SET: assert property (@(posedge clk) disable iff (cold_rst)
      (soft_rst || nmi) |=> (st_sr && st_err && st_bev)); // R8

   AST_ENTRY_SET: assert property (@(posedge clk) disable iff (cold_rst)
      (exc_enter && !soft_rst && !nmi) |=> st_exc); // R9

endmodule

bind priv_status_ctl psr_status_chk u_chk (
   .clk       (clk),
   .cold_rst  (cold_rst),
   .soft_rst  (soft_rst),
   .nmi       (nmi),
   .exc_enter (exc_enter),
   .st_ien    (rd_data[psr_pkg::B_IEN]),
   .st_exc    (rd_data[psr_pkg::B_EXC]),
   .st_err    (rd_data[psr_pkg::B_ERR]),
   .st_sr     (rd_data[psr_pkg::B_SR]),
   .st_bev    (rd_data[psr_pkg::B_BEV]),
   .cur_mode  (cur_mode),
   .irq_req   (irq_req),
   .acc_req   (acc_req),
   .acc_seg   (acc_seg),
   .acc_fault (acc_fault),
   .op64_ok   (op64_ok)
);

// File: tb/test_priv_status_ctl.sv
`timescale 1ns/1ps
module test_priv_status_ctl;

   logic        clk = 1'b0;
   logic        cold_rst = 1'b1;
   logic        soft_rst = 1'b0;
   logic        nmi = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        exc_enter = 1'b0;
   logic        exc_return = 1'b0;
   logic [7:0]  irq_pend = '0;
   logic        acc_req = 1'b0;
   logic [1:0]  acc_seg = '0;
   logic [1:0]  miss_seg = '0;
   logic [1:0]  cur_mode;
   logic        irq_req;
   logic        acc_fault;
   logic        xrefill_sel;
   logic        op64_ok;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   priv_status_ctl i_priv_status_ctl (
      .clk         (clk),
      .cold_rst    (cold_rst),
      .soft_rst    (soft_rst),
      .nmi         (nmi),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .exc_enter   (exc_enter),
      .exc_return  (exc_return),
      .irq_pend    (irq_pend),
      .acc_req     (acc_req),
      .acc_seg     (acc_seg),
      .miss_seg    (miss_seg),
      .cur_mode    (cur_mode),
      .irq_req     (irq_req),
      .acc_fault   (acc_fault),
      .xrefill_sel (xrefill_sel),
      .op64_ok     (op64_ok)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   // 0 soft reset, 1 nmi, 2 entry, 3 return
   task automatic pulse(input int k);
      @(negedge clk);
      case (k)
         0: soft_rst = 1'b1;
         1: nmi = 1'b1;
         2: exc_enter = 1'b1;
         default: exc_return = 1'b1;
      endcase
      @(negedge clk);
      soft_rst = 1'b0;
      nmi = 1'b0;
      exc_enter = 1'b0;
      exc_return = 1'b0;
      #1;
   endtask

   function automatic logic [1:0] exp_mode(input logic e, input logic r, input logic [1:0] pm);
      if (e || r || pm == 2'b00) return 2'b00;
      if (pm == 2'b01) return 2'b01;
      return 2'b10;
   endfunction

   function automatic logic exp_fault(input logic [1:0] m, input int s);
      case (s)
         0: return m != 2'b00;
         1: return m == 2'b10;
         2: return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] masks [5];
      logic [31:0] v;
      masks = '{8'h00, 8'h01, 8'h80, 8'hA5, 8'hFF};

      repeat (3) @(negedge clk);
      cold_rst = 1'b0;
      #1;
      // R7 reset state: only the defined reset bits are checked
      chk("R7 err level after cold", 32'(rd_data[2]), 1);
      chk("R7 boot flag after cold", 32'(rd_data[22]), 1);
      chk("R7 soft flag after cold", 32'(rd_data[20]), 0);
      chk("R7 shutdown after cold", 32'(rd_data[21]), 0);
      chk("R2 kernel after cold", 32'(cur_mode), 0);

      // R1 R2 R4 R5 R6 full sweep of the low byte
      for (int f = 0; f < 256; f++) begin
         logic [7:0] fb;
         logic [1:0] em;
         fb = 8'(f);
         wr(32'(fb));
         chk("R1 readback", rd_data, 32'(fb));
         em = exp_mode(fb[1], fb[2], fb[4:3]);
         chk("R2 mode", 32'(cur_mode), 32'(em));
         chk("R5 wide ops", 32'(op64_ok),
             32'((em == 2'b00) ? 1'b1 : (em == 2'b01) ? fb[6] : fb[5]));
         acc_req = 1'b1;
         for (int s = 0; s < 4; s++) begin
            acc_seg = 2'(s);
            #1;
            chk("R4 access", 32'(acc_fault), 32'(exp_fault(em, s)));
         end
         for (int s = 0; s < 4; s++) begin
            miss_seg = 2'(s);
            #1;
            chk("R6 refill select", 32'(xrefill_sel),
                32'((s == 0) ? fb[7] : (s == 1) ? fb[6] : (s == 2) ? fb[5] : 1'b0));
         end
         acc_req = 1'b0;
         acc_seg = 2'b00;
         #1;
         chk("R4 no request", 32'(acc_fault), 0);
         irq_pend = 8'hFF;
         #1;
         chk("R3 zero mask", 32'(irq_req), 0);
         irq_pend = 8'h00;
      end

      // R3 interrupt sweep
      for (int g = 0; g < 8; g++) begin
         for (int mi = 0; mi < 5; mi++) begin
            logic [2:0] gb;
            gb = 3'(g);
            wr(32'(gb) | (32'(masks[mi]) << 8) | (32'd2 << 3));
            for (int p = 0; p < 10; p++) begin
               logic [7:0] pd;
               pd = (p < 8) ? 8'(1 << p) : ((p == 8) ? 8'h00 : 8'h5A);
               irq_pend = pd;
               #1;
               chk("R3 interrupt", 32'(irq_req),
                   32'(gb[0] && !gb[1] && !gb[2] && |(pd & masks[mi])));
            end
            irq_pend = 8'h00;
         end
      end

      // R1 undefined bits read zero
      wr(32'hFFFF_FFFF);
      chk("R1 write mask", rd_data, 32'h0070_FFFF);

      // R7 cold reset mid-run
      @(negedge clk);
      cold_rst = 1'b1;
      @(negedge clk);
      cold_rst = 1'b0;
      #1;
      chk("R7 err level", 32'(rd_data[2]), 1);
      chk("R7 boot flag", 32'(rd_data[22]), 1);
      chk("R7 soft flag cleared", 32'(rd_data[20]), 0);
      chk("R7 shutdown cleared", 32'(rd_data[21]), 0);

      // R8 soft reset and NMI keep other fields
      v = 32'h0000_A5E9;
      wr(v);
      pulse(0);
      chk("R8 soft reset", rd_data, v | 32'h0050_0004);
      chk("R2 kernel after soft", 32'(cur_mode), 0);
      wr(v);
      pulse(1);
      chk("R8 nmi", rd_data, v | 32'h0050_0004);

      // R9 entry
      wr(32'h0000_0010);
      chk("R2 user", 32'(cur_mode), 2);
      pulse(2);
      chk("R9 entry sets level", rd_data, 32'h0000_0012);
      chk("R2 entry forces kernel", 32'(cur_mode), 0);

      // R10 return order
      wr(32'h0000_0016);
      pulse(3);
      chk("R10 return clears err first", rd_data, 32'h0000_0012);
      pulse(3);
      chk("R10 return clears exc", rd_data, 32'h0000_0010);
      chk("R2 back to user", 32'(cur_mode), 2);

      // R11 strobe beats write
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 32'h0000_00FF;
      exc_enter = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      exc_enter = 1'b0;
      #1;
      chk("R11 write dropped under entry", rd_data, 32'h0000_0012);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 32'h0000_0000;
      soft_rst = 1'b1;
      exc_return = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      soft_rst = 1'b0;
      exc_return = 1'b0;
      #1;
      chk("R11 soft beats return", rd_data, 32'h0050_0016);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule